// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

This block is one 32-bit countdown channel for a timer unit. Software reaches it through a small word-addressed register window. The window holds a reload constant, the live counter, a control word and a spare capture word. A prescaler divides the block clock by a power of four, chosen by a 3-bit code in the control word, and each prescaled tick lowers the counter by one. If a tick arrives while the counter is at zero, the counter takes the reload constant and a sticky underflow flag is set. The interrupt output is high while both that flag and its enable bit are set.

A run input from the parent unit starts and stops the channel. The input drives a two-state machine. HOLD is the reset state. The *start* transition goes from HOLD to RUN when run is sampled high, and the *stop* transition goes from RUN to HOLD when run is sampled low. Counting and prescaling happen only in RUN. In HOLD the count and the prescaler phase keep their values. Software can clear the flag by writing 0 to it, but no write can set it.

Top module: `rld_timer`

## Requirements
- R1: After reset, the reload constant reads 0xFFFFFFFF, the counter reads 0xFFFFFFFF, the control word reads 0 and `irq_o` is low.
- R2: The word offset is the byte address bits [3:2]. Offset 0 is the reload constant, 1 is the counter, 2 is the control word and 3 is the capture word. A write with `wr_en_i` high takes effect at the next clock edge, and reads are combinational from `addr_i`.
- R3: Control bits [2:0] select the prescale code. Codes 0, 1, 2, 3 and 4 give one tick every 4, 16, 64, 256 and 1024 clocks in RUN.
- R4: Prescale codes 5, 6 and 7 are reserved. With one of these codes no ticks occur, so the counter holds its value.
- R5: Each tick lowers a nonzero counter by one. A tick while the counter is 0 loads the reload constant (the value before any same-cycle write to it) and sets the underflow flag.
- R6: The underflow flag (control bit 8) is cleared only by a control write with bit 8 = 0. A control write with bit 8 = 1 leaves the flag unchanged.
- R7: `irq_o` is high exactly when the underflow flag and the interrupt enable (control bit 5) are both set.
- R8: A control read returns the prescale code in bits [2:0], the enable in bit 5 and the flag in bit 8. All other bits, including bit 9 and bits [15:10], read 0 whatever was written.
- R9: The machine enters RUN one clock after `run_i` is sampled high and enters HOLD one clock after `run_i` is sampled low. In HOLD the counter and the prescaler phase are frozen.
- R10: A counter write loads the written value at the next clock. It overrides any decrement or underflow in the same cycle, and no flag is set in that cycle.
- R11: A control write resets the prescaler phase to zero and suppresses any tick in its own cycle. The next tick then comes a full divide period after the write.
- R12: When the capture word is present, it stores the last value written to offset 3 and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request from the parent unit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address; bits [3:2] give the word offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the word at `addr_i` |
| irq_o | output | 1 | Underflow interrupt request |

## Verification
The hardest case to reach is an underflow that lands in the same cycle as a software action: a counter write, a control write, or a reload-constant write. Each of these must win or lose according to R5, R10 and R11. The random stimulus keeps the reload constant and counter values small and mostly uses the fastest prescale codes. It also writes often while RUN is toggling, so underflows happen every few dozen clocks and coincide with writes many times. Directed steps set up the flag, hold the channel in HOLD, and then try to clear the flag first by writing 1 to it and then by writing 0.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;

    // word offsets: software decodes them, so they are fixed
    localparam int OFS_RELOAD = 0;
    localparam int OFS_COUNT  = 1;
    localparam int OFS_CTRL   = 2;
    localparam int OFS_CAPT   = 3;

    // control bit positions
    localparam int BIT_IE = 5;
    localparam int BIT_UF = 8;

    localparam int PSC_W     = 3;
    localparam int PSC_CODES = 5;
    localparam int DIV_W     = 2 * PSC_CODES;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    function automatic logic psc_valid(input logic [PSC_W-1:0] code);
        return int'(code) < PSC_CODES;
    endfunction

    // terminal value of the divide counter: 4^(code+1) - 1
    function automatic logic [DIV_W-1:0] psc_limit(input logic [PSC_W-1:0] code);
        int span;
        span = 4 << (2 * int'(code));
        return DIV_W'(span - 1);
    endfunction

endpackage

// File: rtl/rld_prescaler.sv
module rld_prescaler
    import rld_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] code_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;
    logic             ok;

    always_comb begin
        lim = psc_limit(code_i);
        ok  = psc_valid(code_i);
    end

    assign tick_o = active_i && ok && !restart_i && (div_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart_i) begin
            div_q <= '0;
        end else if (active_i && ok) begin
            div_q <= (div_q == lim) ? '0 : div_q + 1'b1;
        end
    end

    // R11: control write restarts the phase
    a_r11_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (div_q == '0));

    // R9: phase frozen while not running
    a_r9_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !restart_i) |=> $stable(div_q));

endmodule

// File: rtl/rld_counter.sv
module rld_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o
);

    logic [W-1:0] cnt_q;

    assign uf_o  = tick_i && !load_i && (cnt_q == '0);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
        end
    end

    // R5: decrement by one on a tick
    a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: reload at zero
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)));

    // R10: software load wins
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/rld_timer.sv
module rld_timer
    import rld_timer_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter bit HAS_CAPTURE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int OFS_LSB = 2;

    run_state_e        state_q, state_d;
    logic              active;
    logic [1:0]        ofs;
    logic              wr_reload, wr_count, wr_ctrl, wr_capt;
    logic [DATA_W-1:0] reload_q;
    logic [PSC_W-1:0]  psc_q;
    logic              ie_q;
    logic              flag_q;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] capt;
    logic              tick;
    logic              uf;

    assign ofs       = addr_i[OFS_LSB +: 2];
    assign wr_reload = wr_en_i && (int'(ofs) == OFS_RELOAD);
    assign wr_count  = wr_en_i && (int'(ofs) == OFS_COUNT);
    assign wr_ctrl   = wr_en_i && (int'(ofs) == OFS_CTRL);
    assign wr_capt   = wr_en_i && (int'(ofs) == OFS_CAPT);

    // run state machine: register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // run state machine: transitions (start, stop) and outputs
    always_comb begin
        state_d = state_q;
        active  = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (run_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                active = 1'b1;
                if (!run_i) state_d = ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '1;
            psc_q    <= '0;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wdata_i;
            if (wr_ctrl) begin
                psc_q <= wdata_i[PSC_W-1:0];
                ie_q  <= wdata_i[BIT_IE];
            end
            if (uf)                            flag_q <= 1'b1;
            else if (wr_ctrl && !wdata_i[BIT_UF]) flag_q <= 1'b0;
        end
    end

    generate
        if (HAS_CAPTURE) begin : g_capt
            logic [DATA_W-1:0] capt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       capt_q <= '0;
                else if (wr_capt) capt_q <= wdata_i;
            end
            assign capt = capt_q;
        end else begin : g_no_capt
            assign capt = '0;
        end
    endgenerate

    rld_prescaler u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .restart_i (wr_ctrl),
        .code_i    (psc_q),
        .tick_o    (tick)
    );

    rld_counter #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (wr_count),
        .load_val_i (wdata_i),
        .reload_i   (reload_q),
        .cnt_o      (cnt),
        .uf_o       (uf)
    );

    always_comb begin
        rdata_o = '0;
        unique case (ofs)
            2'd0: rdata_o = reload_q;
            2'd1: rdata_o = cnt;
            2'd2: begin
                rdata_o[PSC_W-1:0] = psc_q;
                rdata_o[BIT_IE]    = ie_q;
                rdata_o[BIT_UF]    = flag_q;
            end
            2'd3: rdata_o = capt;
            default: rdata_o = '0;
        endcase
    end

    assign irq_o = flag_q & ie_q;

    // R6: flag survives everything but a clearing write
    a_r6_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_ctrl && !wdata_i[BIT_UF])) |=> flag_q);

    // R6: flag only rises after an underflow
    a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(uf));

    // R4: reserved codes stall the counter
    a_r4_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!psc_valid(psc_q) && !wr_count) |=> $stable(cnt));

    // R9: frozen count in HOLD
    a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !wr_count) |=> $stable(cnt));

    // R7: interrupt implies enable
    a_r7_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> rdata_o[BIT_IE] || int'(ofs) != OFS_CTRL);

endmodule

// File: tb/rld_timer_tb.sv
module rld_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_rel, m_cnt, m_capt;
    logic [2:0]  m_psc;
    logic        m_ie, m_flag, m_run;
    int          m_div;

    always #4 clk = ~clk;

    rld_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a[3:2])
            2'd0: return m_rel;
            2'd1: return m_cnt;
            2'd2: return 32'(m_psc) | (32'(m_ie) << 5) | (32'(m_flag) << 8);
            default: return m_capt;
        endcase
    endfunction

    function automatic int div_span(input logic [2:0] c);
        return 4 << (2 * int'(c));
    endfunction

    task automatic model_reset();
        m_rel = '1; m_cnt = '1; m_capt = '0;
        m_psc = '0; m_ie = 0; m_flag = 0; m_run = 0; m_div = 0;
    endtask

    task automatic model_step(input logic w, input logic [3:0] a,
                              input logic [31:0] d, input logic r);
        logic cw, nw, ok, tk, u;
        int   lim;
        cw  = w && a[3:2] == 2'd2;
        nw  = w && a[3:2] == 2'd1;
        ok  = m_psc < 3'd5;
        lim = ok ? div_span(m_psc) - 1 : 0;
        tk  = m_run && ok && !cw && m_div == lim;
        u   = tk && !nw && m_cnt == 0;
        if (cw)             m_div = 0;
        else if (m_run && ok) m_div = (m_div == lim) ? 0 : m_div + 1;
        if (nw)      m_cnt = d;
        else if (tk) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
        if (u)                 m_flag = 1'b1;
        else if (cw && !d[8])  m_flag = 1'b0;
        if (cw) begin m_psc = d[2:0]; m_ie = d[5]; end
        if (w && a[3:2] == 2'd0) m_rel = d;
        if (w && a[3:2] == 2'd3) m_capt = d;
        m_run = r;
    endtask

    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                        input logic r, input string tag);
        logic [31:0] e;
        @(negedge clk);
        wr_en_i = w; addr_i = a; wdata_i = d; run_i = r;
        #1;
        e = exp_rd(a);
        checks++;
        if (rdata_o !== e) begin
            errs++;
            $display("FAIL %s rdata addr=%0h actual=%08h expected=%08h", tag, a, rdata_o, e);
        end
        checks++;
        if (irq_o !== (m_flag & m_ie)) begin
            errs++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq_o, m_flag & m_ie);
        end
        @(posedge clk);
        model_step(w, a, d, r);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic cur_run;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values on every offset
        step(0, 4'h0, 0, 0, "R1");
        step(0, 4'h4, 0, 0, "R1");
        step(0, 4'h8, 0, 0, "R1");
        step(0, 4'hC, 0, 0, "R1");

        // R2: writes through each offset, low address bits ignored
        step(1, 4'h1, 32'd3, 0, "R2");
        step(1, 4'h6, 32'd2, 0, "R2");
        step(1, 4'h8, 32'h0000_0020, 0, "R2");
        step(0, 4'h0, 0, 0, "R2");
        step(0, 4'h5, 0, 0, "R2");

        // R3 R5 R7 R9: run at divide-by-4 through several underflows
        for (int i = 0; i < 60; i++) step(0, 4'h4, 0, 1, "R5");
        for (int i = 0; i < 3; i++) step(0, 4'h8, 0, 1, "R7");
        // R9: freeze
        for (int i = 0; i < 10; i++) step(0, 4'h4, 0, 0, "R9");

        // R6: write 1 to flag keeps it, write 0 clears it
        step(1, 4'h8, 32'h0000_0120, 0, "R6");
        step(0, 4'h8, 0, 0, "R6");
        step(1, 4'h8, 32'h0000_0020, 0, "R6");
        step(0, 4'h8, 0, 0, "R7");

        // R8: reserved and capture-flag bits never stored
        step(1, 4'h8, 32'hFFFF_FEFF, 0, "R8");
        step(0, 4'h8, 0, 0, "R8");

        // R4: reserved code 7 set above; counter must hold while running
        step(1, 4'h4, 32'd9, 1, "R4");
        for (int i = 0; i < 30; i++) step(0, 4'h4, 0, 1, "R4");

        // R3 R11: divide-by-16 then restart the phase mid-period
        step(1, 4'h8, 32'h0000_0001, 1, "R3");
        for (int i = 0; i < 40; i++) step(0, 4'h4, 0, 1, "R3");
        step(1, 4'h8, 32'h0000_0001, 1, "R11");
        for (int i = 0; i < 20; i++) step(0, 4'h4, 0, 1, "R11");

        // R12: capture word
        step(1, 4'hC, 32'hA5A5_0F0F, 0, "R12");
        step(0, 4'hF, 0, 0, "R12");

        // R10: counter writes during fast ticking, plus random mix
        step(1, 4'h8, 32'h0000_0020, 1, "R10");
        cur_run = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            logic        w;
            logic [3:0]  a;
            logic [31:0] d;
            int          p;
            if ($urandom % 50 == 0) cur_run = ~cur_run;
            w = ($urandom % 5) == 0;
            a = 4'($urandom);
            d = $urandom;
            if (a[3:2] == 2'd2) begin
                p = $urandom % 10;
                d[2:0] = (p < 5) ? 3'd0 : (p < 7) ? 3'd1 : (p < 8) ? 3'd2 : 3'(5 + $urandom % 3);
            end else if (a[3:2] != 2'd3 && ($urandom % 8) != 0) begin
                d = $urandom % 12;
            end
            step(w, a, d, cur_run, "R10");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule